// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Policy Controller

This block guards a bank of one-time-programmable fuse rows and the 32-bit shadow registers that hold their power-on image. Requesting hosts present one request per cycle. Each request carries an operation, a host identifier and an index. The block decides whether to grant it and answers one cycle later with a status code and, where allowed, data. Reads are policed per 32-bit shadow register. Every register has an owner identifier and a secure flag supplied on configuration inputs. Programming, permanent locking and lock-status queries work on whole hardware rows of a narrower width.

Only a single configured write host may program fuses or lock rows. A row write carries a value and a bit mask. Because a fuse can only go from 0 to 1, the new row content is the old content ORed with the masked value. A permanent lock bit per row blocks all later programming of that row. This lock state is held in storage that the reset input does not clear. A volatile soft lock blocks every row write until the next reset. Shadow registers are an input image and are not refreshed by row writes.

Top module: `otp_policy_ctrl`

## Requirements
- R1: A request sampled with `req_valid` high while `rst` is low produces exactly one response, with `rsp_valid` high, on the next clock edge. While `rst` is high and on the first cycle after it, `rsp_valid` is low.
- R2: A read (op 0) of shadow register `i` is granted with status 0 and returns `shadow_data[32*i +: 32]` under these conditions. The owner field `cfg_owner[8*i +: 8]` is 128, or the owner equals the requesting host and is not 0. Owner 0 denies every host. Any other mismatch returns status 1 (permission denied).
- R3: A read of a register whose `cfg_secure[i]` bit is set is refused with status 2 (secure denied), even for its owner. Every response with a non-zero status carries all-zero data.
- R4: Row writes (op 1), permanent locks (op 2) and soft-lock commands (op 4) from any host other than `cfg_write_host` get status 1 and change no state.
- R5: A granted row write sets the row to old value OR (`req_wdata` AND `req_wmask`). It returns status 0, with the new row content in the low ROW_W data bits.
- R6: A row write to a permanently locked row gets status 3 (row locked), and no bit of that row changes.
- R7: After a granted soft-lock command, every row write gets status 4 (soft locked) until the next reset. Lock commands and queries are still served, and a reset clears the soft lock.
- R8: A lock-status query (op 3), open to any host, returns status 0. Its data holds the row content in bits ROW_W-1:0 and the row's permanent lock bit in bit ROW_W. Lock bits and row contents survive reset.
- R9: Status 5 (bad index) is returned in three cases: a read with an index of NUM_REGS or more, a row operation with an index of NUM_ROWS or more, and an operation code of 5, 6 or 7.
- R10: Row writes are judged in a fixed order: write-host check, then index range, then soft lock, then row lock. A non-writer hitting a locked row sees status 1, and the write host hitting a locked row under soft lock sees status 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (clears soft lock and response, not fuses) |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 row write, 2 permanent lock, 3 lock query, 4 soft lock |
| req_host | input | 8 | Requesting host identifier |
| req_idx | input | IDX_W | Shadow register index (read) or row index (row ops) |
| req_wdata | input | ROW_W | Value for a row write |
| req_wmask | input | ROW_W | Bits of `req_wdata` to program |
| cfg_owner | input | NUM_REGS*8 | Owner identifier per shadow register |
| cfg_secure | input | NUM_REGS | Secure flag per shadow register |
| cfg_write_host | input | 8 | The single host allowed to program and lock |
| shadow_data | input | NUM_REGS*32 | Power-on image of the fuse array |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | 0 ok, 1 permission, 2 secure, 3 row locked, 4 soft locked, 5 bad index |
| rsp_data | output | 32 | Read value, new row content, or lock query result |

## Verification
The interactions that matter most are a state change by one request and the judgement of the very next request, issued in the following cycle. A lock command is followed directly by a write to the same row. A soft-lock command is followed directly by a write to an open row. A reset is followed by a query and a write to confirm that the lock bits persist while the soft lock clears. The bench issues these back to back and judges each response against its own model of rows, lock bits and soft lock. The same model also follows a long run of seeded random requests with periodic resets.

// File: rtl/otp_pol_pkg.sv
package otp_pol_pkg;

    localparam int HOST_W = 8;
    localparam int DATA_W = 32;

    localparam logic [HOST_W-1:0] OWNER_ANY  = 8'd128;
    localparam logic [HOST_W-1:0] OWNER_NONE = 8'd0;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_LOCK     = 3'd2,
        OP_QUERY    = 3'd3,
        OP_SOFTLOCK = 3'd4
    } otp_op_e;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_PERM     = 3'd1,
        ST_SECURE   = 3'd2,
        ST_ROWLOCK  = 3'd3,
        ST_SOFTLOCK = 3'd4,
        ST_BADIDX   = 3'd5
    } otp_status_e;

    typedef struct packed {
        logic              valid;
        otp_status_e       status;
        logic [DATA_W-1:0] data;
    } otp_rsp_t;

    // Owner policy: 0 blocks all, 128 opens to all, otherwise exact match.
    function automatic logic owner_allows(input logic [HOST_W-1:0] owner,
                                          input logic [HOST_W-1:0] host);
        if (owner == OWNER_NONE) return 1'b0;
        if (owner == OWNER_ANY)  return 1'b1;
        return owner == host;
    endfunction

endpackage

// File: rtl/otp_read_gate.sv
module otp_read_gate
    import otp_pol_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 6
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [HOST_W-1:0]          host,
    input  logic [NUM_REGS*HOST_W-1:0] owner_flat,
    input  logic [NUM_REGS-1:0]        secure,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    output otp_status_e                status,
    output logic [DATA_W-1:0]          data
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic             in_range;
    logic [SEL_W-1:0] sel;
    logic [HOST_W-1:0] owner;

    always_comb begin
        in_range = (32'(idx) < NUM_REGS);
        sel      = idx[SEL_W-1:0];
        owner    = owner_flat[sel*HOST_W +: HOST_W];
        data     = '0;
        if (!in_range) begin
            status = ST_BADIDX;
        end else if (!owner_allows(owner, host)) begin
            status = ST_PERM;
        end else if (secure[sel]) begin
            status = ST_SECURE;
        end else begin
            status = ST_OK;
            data   = shadow_flat[sel*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/otp_row_gate.sv
module otp_row_gate
    import otp_pol_pkg::*;
#(
    parameter int NUM_ROWS = 42,
    parameter int IDX_W    = 6
) (
    input  otp_op_e           op,
    input  logic [HOST_W-1:0] host,
    input  logic [HOST_W-1:0] write_host,
    input  logic [IDX_W-1:0]  idx,
    input  logic              soft_locked,
    input  logic              row_locked,
    output otp_status_e       status,
    output logic              do_write,
    output logic              do_lock,
    output logic              do_soft
);
    logic in_range;
    logic is_writer;

    always_comb begin
        in_range  = (32'(idx) < NUM_ROWS);
        is_writer = (host == write_host);
        status    = ST_OK;
        do_write  = 1'b0;
        do_lock   = 1'b0;
        do_soft   = 1'b0;
        case (op)
            OP_WRITE: begin
                if (!is_writer)       status = ST_PERM;
                else if (!in_range)   status = ST_BADIDX;
                else if (soft_locked) status = ST_SOFTLOCK;
                else if (row_locked)  status = ST_ROWLOCK;
                else                  do_write = 1'b1;
            end
            OP_LOCK: begin
                if (!is_writer)     status = ST_PERM;
                else if (!in_range) status = ST_BADIDX;
                else                do_lock = 1'b1;
            end
            OP_SOFTLOCK: begin
                if (!is_writer) status = ST_PERM;
                else            do_soft = 1'b1;
            end
            OP_QUERY: begin
                if (!in_range) status = ST_BADIDX;
            end
            default: status = ST_BADIDX;
        endcase
    end

endmodule

// File: rtl/otp_row_store.sv
module otp_row_store
    import otp_pol_pkg::*;
#(
    parameter int NUM_ROWS = 42,
    parameter int ROW_W    = 25,
    parameter int IDX_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_bits,
    input  logic                      lock_en,
    input  logic                      soft_set,
    output logic [ROW_W-1:0]          sel_row,
    output logic                      sel_lock,
    output logic                      soft_lk,
    output logic [NUM_ROWS-1:0]       lock_vec,
    output logic [NUM_ROWS*ROW_W-1:0] row_vec
);
    localparam int SEL_W = $clog2(NUM_ROWS);

    // Fuse contents and permanent locks: start unprogrammed, never reset.
    logic [NUM_ROWS-1:0][ROW_W-1:0] row_q  = '0;
    logic [NUM_ROWS-1:0]            lock_q = '0;
    logic                           soft_q;
    logic                           in_range;
    logic [SEL_W-1:0]               sel;

    always_comb begin
        in_range = (32'(idx) < NUM_ROWS);
        sel      = idx[SEL_W-1:0];
        sel_row  = in_range ? row_q[sel]  : '0;
        sel_lock = in_range ? lock_q[sel] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en && in_range)   row_q[sel]  <= row_q[sel] | wr_bits;
        if (!rst && lock_en && in_range) lock_q[sel] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           soft_q <= 1'b0;
        else if (soft_set) soft_q <= 1'b1;
    end

    assign soft_lk  = soft_q;
    assign lock_vec = lock_q;
    assign row_vec  = row_q;

endmodule

// File: rtl/otp_policy_ctrl.sv
module otp_policy_ctrl
    import otp_pol_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int NUM_ROWS = 42,
    parameter  int ROW_W    = 25,
    localparam int IDX_W    = $clog2((NUM_REGS > NUM_ROWS) ? NUM_REGS : NUM_ROWS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [2:0]                 req_op,
    input  logic [HOST_W-1:0]          req_host,
    input  logic [IDX_W-1:0]           req_idx,
    input  logic [ROW_W-1:0]           req_wdata,
    input  logic [ROW_W-1:0]           req_wmask,
    input  logic [NUM_REGS*HOST_W-1:0] cfg_owner,
    input  logic [NUM_REGS-1:0]        cfg_secure,
    input  logic [HOST_W-1:0]          cfg_write_host,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_data,
    output logic                       rsp_valid,
    output logic [2:0]                 rsp_status,
    output logic [DATA_W-1:0]          rsp_data
);
    otp_op_e                   op;
    otp_status_e               rd_status, row_status;
    logic [DATA_W-1:0]         rd_data;
    logic                      g_write, g_lock, g_soft;
    logic [ROW_W-1:0]          prog_bits;
    logic [ROW_W-1:0]          sel_row;
    logic                      sel_lock;
    logic                      soft_lk;
    logic [NUM_ROWS-1:0]       lock_vec;
    logic [NUM_ROWS*ROW_W-1:0] row_vec;
    otp_rsp_t                  rsp_d, rsp_q;

    assign op        = otp_op_e'(req_op);
    assign prog_bits = req_wdata & req_wmask;

    otp_read_gate #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rd_gate_i (
        .idx(req_idx), .host(req_host), .owner_flat(cfg_owner),
        .secure(cfg_secure), .shadow_flat(shadow_data),
        .status(rd_status), .data(rd_data)
    );

    otp_row_gate #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) row_gate_i (
        .op(op), .host(req_host), .write_host(cfg_write_host), .idx(req_idx),
        .soft_locked(soft_lk), .row_locked(sel_lock), .status(row_status),
        .do_write(g_write), .do_lock(g_lock), .do_soft(g_soft)
    );

    otp_row_store #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst(rst), .idx(req_idx),
        .wr_en(req_valid && g_write), .wr_bits(prog_bits),
        .lock_en(req_valid && g_lock), .soft_set(req_valid && g_soft),
        .sel_row(sel_row), .sel_lock(sel_lock), .soft_lk(soft_lk),
        .lock_vec(lock_vec), .row_vec(row_vec)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        rsp_d.status = (op == OP_READ) ? rd_status : row_status;
        if (req_valid && rsp_d.status == ST_OK) begin
            case (op)
                OP_READ:  rsp_d.data = rd_data;
                OP_WRITE: rsp_d.data = DATA_W'(sel_row | prog_bits);
                OP_QUERY: rsp_d.data = DATA_W'({sel_lock, sel_row});
                default:  rsp_d.data = '0;
            endcase
        end
        if (!req_valid) rsp_d.status = ST_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_status = rsp_q.status;
    assign rsp_data   = rsp_q.data;

endmodule

// File: rtl/otp_policy_ctrl_chk.sv
module otp_policy_ctrl_chk #(
    parameter int NUM_ROWS = 42,
    parameter int ROW_W    = 25
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic [2:0]                req_op,
    input logic [7:0]                req_host,
    input logic [7:0]                cfg_write_host,
    input logic                      rsp_valid,
    input logic [2:0]                rsp_status,
    input logic [31:0]               rsp_data,
    input logic                      soft_lk,
    input logic [NUM_ROWS-1:0]       lock_vec,
    input logic [NUM_ROWS*ROW_W-1:0] row_vec
);
    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_REJECT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 3'd0) |-> (rsp_data == 32'd0)); // R3

    AST_NONWRITER_DENIED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd4)
         && req_host != cfg_write_host) |=> (rsp_status == 3'd1)); // R4

    AST_SOFT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && soft_lk) |=> (rsp_status != 3'd0)); // R7

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        AST_LOCKED_ROW_STABLE: assert property (@(posedge clk) disable iff (rst)
            lock_vec[r] |=> $stable(row_vec[r*ROW_W +: ROW_W])); // R6
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
            lock_vec[r] |=> lock_vec[r]); // R8
    end

endmodule

bind otp_policy_ctrl otp_policy_ctrl_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_host(req_host), .cfg_write_host(cfg_write_host),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .soft_lk(soft_lk), .lock_vec(lock_vec), .row_vec(row_vec)
);

// File: tb/otp_policy_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_policy_ctrl_tb_top;
    localparam int NUM_REGS = 32;
    localparam int NUM_ROWS = 42;
    localparam int ROW_W    = 25;
    localparam int IDX_W    = 6;
    localparam int WH       = 5;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic [2:0]               req_op = '0;
    logic [7:0]               req_host = '0;
    logic [IDX_W-1:0]         req_idx = '0;
    logic [ROW_W-1:0]         req_wdata = '0;
    logic [ROW_W-1:0]         req_wmask = '0;
    logic [NUM_REGS*8-1:0]    cfg_owner;
    logic [NUM_REGS-1:0]      cfg_secure;
    logic [7:0]               cfg_write_host = 8'(WH);
    logic [NUM_REGS*32-1:0]   shadow_data;
    logic                     rsp_valid;
    logic [2:0]               rsp_status;
    logic [31:0]              rsp_data;

    logic [7:0]       own_a  [NUM_REGS];
    logic             sec_a  [NUM_REGS];
    logic [31:0]      shd_a  [NUM_REGS];
    logic [ROW_W-1:0] m_row  [NUM_ROWS];
    logic             m_lock [NUM_ROWS];
    logic             m_soft;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    otp_policy_ctrl #(.NUM_REGS(NUM_REGS), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_host(req_host), .req_idx(req_idx), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .cfg_owner(cfg_owner), .cfg_secure(cfg_secure),
        .cfg_write_host(cfg_write_host), .shadow_data(shadow_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drives one request at a falling edge, predicts, checks at the next one.
    task automatic issue(input int op, input int host, input int idx,
                         input logic [ROW_W-1:0] wd, input logic [ROW_W-1:0] wm,
                         input string req);
        int          est;
        logic [31:0] edat;
        est  = 0;
        edat = '0;
        case (op)
            0: begin
                if (idx >= NUM_REGS) est = 5;
                else if (own_a[idx] == 8'd0 ||
                         (own_a[idx] != 8'd128 && own_a[idx] != 8'(host))) est = 1;
                else if (sec_a[idx]) est = 2;
                else edat = shd_a[idx];
            end
            1: begin
                if (host != WH) est = 1;
                else if (idx >= NUM_ROWS) est = 5;
                else if (m_soft) est = 4;
                else if (m_lock[idx]) est = 3;
                else begin
                    m_row[idx] = m_row[idx] | (wd & wm);
                    edat = 32'(m_row[idx]);
                end
            end
            2: begin
                if (host != WH) est = 1;
                else if (idx >= NUM_ROWS) est = 5;
                else m_lock[idx] = 1'b1;
            end
            3: begin
                if (idx >= NUM_ROWS) est = 5;
                else edat = 32'({m_lock[idx], m_row[idx]});
            end
            4: begin
                if (host != WH) est = 1;
                else m_soft = 1'b1;
            end
            default: est = 5;
        endcase
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_host  = 8'(host);
        req_idx   = IDX_W'(idx);
        req_wdata = wd;
        req_wmask = wm;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_status, rsp_data}, {1'b1, 3'(est), edat});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_soft = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", {35'd0, rsp_valid}, 36'd0);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_REGS; i++) begin
            int pick = $urandom % 4;
            own_a[i] = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd128 : 8'(1 + $urandom % 7);
            sec_a[i] = ($urandom % 4) == 0;
            shd_a[i] = $urandom;
        end
        own_a[0] = 8'd128; sec_a[0] = 1'b0;
        own_a[1] = 8'd0;   sec_a[1] = 1'b0;
        own_a[2] = 8'd3;   sec_a[2] = 1'b0;
        own_a[3] = 8'd128; sec_a[3] = 1'b1;
        own_a[4] = 8'd3;   sec_a[4] = 1'b1;
        for (int i = 0; i < NUM_REGS; i++) begin
            cfg_owner[i*8 +: 8]    = own_a[i];
            cfg_secure[i]          = sec_a[i];
            shadow_data[i*32 +: 32] = shd_a[i];
        end
        for (int r = 0; r < NUM_ROWS; r++) begin
            m_row[r]  = '0;
            m_lock[r] = 1'b0;
        end
        m_soft = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", {35'd0, rsp_valid}, 36'd0);

        // Read policy
        issue(0, 3, 0, '0, '0, "R2");
        issue(0, 7, 0, '0, '0, "R2");
        issue(0, 3, 1, '0, '0, "R2");
        issue(0, 3, 2, '0, '0, "R2");
        issue(0, 4, 2, '0, '0, "R2");
        issue(0, 3, 3, '0, '0, "R3");
        issue(0, 3, 4, '0, '0, "R3");
        issue(0, 3, 40, '0, '0, "R9");

        // Writer identity and masked programming
        issue(1, 2, 0, 25'h1FFFFFF, 25'h1FFFFFF, "R4");
        issue(1, WH, 0, 25'h1FFFFFF, 25'h0F0F0F, "R5");
        issue(1, WH, 0, 25'h0000F0, 25'h1000FF, "R5");
        issue(3, 1, 0, '0, '0, "R8");
        issue(2, 6, 1, '0, '0, "R4");

        // Lock then write same row back to back
        issue(1, WH, 1, 25'h0000AA, 25'h0000FF, "R5");
        issue(2, WH, 1, '0, '0, "R8");
        issue(1, WH, 1, 25'h1FFFFFF, 25'h1FFFFFF, "R6");
        issue(3, 2, 1, '0, '0, "R6");
        issue(1, 3, 1, 25'h1, 25'h1, "R10");
        issue(1, WH, 50, 25'h1, 25'h1, "R9");
        issue(2, WH, 45, '0, '0, "R9");
        issue(6, WH, 0, '0, '0, "R9");

        // Soft lock then write back to back
        issue(4, 2, 0, '0, '0, "R4");
        issue(4, WH, 0, '0, '0, "R7");
        issue(1, WH, 2, 25'h3, 25'h3, "R7");
        issue(1, WH, 1, 25'h3, 25'h3, "R10");
        issue(2, WH, 3, '0, '0, "R7");
        issue(3, 4, 3, '0, '0, "R7");

        // Reset keeps fuses and locks, clears soft lock
        do_reset();
        issue(3, 0, 1, '0, '0, "R8");
        issue(1, WH, 2, 25'h3, 25'h3, "R7");
        issue(1, WH, 3, 25'h3, 25'h3, "R6");

        // Seeded random traffic
        for (int n = 0; n < 800; n++) begin
            int op   = $urandom % 6;
            int host = (($urandom % 2) == 0) ? WH : int'($urandom % 8);
            int idx  = $urandom % 48;
            string tag;
            if (op == 2 && ($urandom % 6) != 0) op = 3;
            if (op == 4 && ($urandom % 4) != 0) op = 0;
            case (op)
                0: tag = "R2";
                1: tag = "R5";
                2: tag = "R8";
                3: tag = "R8";
                4: tag = "R7";
                default: tag = "R9";
            endcase
            issue(op, host, idx, 25'($urandom), 25'($urandom), tag);
            if (n % 200 == 199) do_reset();
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule